// File: doc/BRIEF.md
# Three-Wire Configuration Register Write Port

This block is a write-only serial slave for a three-wire control bus. It has a clock pin, a data pin and an active-low enable pin. It loads a bank of configuration registers that later logic reads as parallel outputs. The block samples the three pins into a faster system clock through two-flop synchronizers and finds their edges there. While the enable pin is low, each rising edge of the serial clock shifts one data bit into a 22-bit shift register, most significant bit first. When the enable pin rises, the contents of the shift register are committed as one word:

- The 4 least significant bits are the register address.
- The 18 bits above them are the data.

Only the last 22 bits clocked before the commit count. A word may be sent with any number of bits:

- With more than 22 bits, the earlier bits drop out of the shift register.
- With fewer than 22 bits, the missing leading bits are zero, because the shift register is cleared each time the enable pin falls.

The bank has 16 address slots. A parameter mask marks which slots hold a register. A write to any other slot is dropped. A second mask marks the frequency-setting slots. A committed write to one of those slots raises a one-cycle retune request. The same request is also raised on the first cycle after reset and when the powerdown input is released. The powerdown input is synchronous to the system clock.

Top module: `cfgser_top`

## Requirements
- R1: A committed word places its 4 least significant bits in the address and its upper 18 bits in the data. With the default masks, addresses 0 to 11 hold registers.
- R2: Bits enter most significant first: the first bit clocked of a full 22-bit word becomes data bit 17.
- R3: A rising edge on `sen_n_i` writes the data into the addressed register. The new value appears on `regs_o` (slot n at bits n*18+17..n*18) in the system cycle after the third rising `clk_i` edge that follows the pin change. A later write to the same address replaces the earlier value, and no other slot changes.
- R4: Serial clock edges while `sen_n_i` is high do not alter any register and raise no retune request.
- R5: When more than 22 bits are clocked, only the last 22 form the word.
- R6: When fewer than 22 bits are clocked, the missing leading bits read as zero. This includes a commit with no clock edges at all, which writes zero to address 0.
- R7: While `rst_i` is high, every register and `retune_o` are zero.
- R8: A write to an address without a register (12 to 15 by default) leaves that slot reading zero and raises no retune request.
- R9: A write to a frequency-setting address (3, 4 or 5 by default) raises `retune_o` for exactly one cycle, in the same cycle the register updates. A write to any other address does not raise it.
- R10: `retune_o` is high for the one cycle that follows the first rising clock edge after `rst_i` falls.
- R11: `retune_o` is high for one cycle after the first clock edge that samples `pwdn_i` low after it was high. It stays low while `pwdn_i` is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| sen_n_i | input | 1 | Active-low serial enable pin; its rising edge commits the word |
| pwdn_i | input | 1 | Powerdown request, synchronous to clk_i |
| regs_o | output | 288 | Register bank contents, 16 slots of 18 bits |
| retune_o | output | 1 | One-cycle request to retune |

## Verification
A change on a serial pin passes through two synchronizer flops and one edge-detect compare. The bench's reference model therefore schedules each commit to land three system edges after the enable pin rises. Both the register value and any retune pulse from that commit are checked at the falling edge that follows. Boot and wake pulses come from synchronous inputs, so they are scheduled one edge after the change. The model is compared with `regs_o` and `retune_o` at every falling edge. Directed checks then sample the same cycles by name, which catches a pulse that is one cycle early, one cycle late or too long.

// File: rtl/cfgser_pkg.sv
`timescale 1ns/1ps
package cfgser_pkg;

    parameter int unsigned DATA_W      = 18;
    parameter int unsigned ADDR_W      = 4;
    parameter int unsigned WORD_W      = DATA_W + ADDR_W;
    parameter int unsigned NREG        = 1 << ADDR_W;
    parameter int unsigned SYNC_STAGES = 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] raw_word_t;

    // Data occupies the upper bits (sent first), address the lowest bits.
    typedef struct packed {
        data_t data;
        addr_t addr;
    } word_t;

    // Synchronized pin levels; sen_lvl is the raw level of the active-low enable.
    typedef struct packed {
        logic sclk;
        logic sdata;
        logic sen_lvl;
    } pins_t;

    // Reasons a retune request may be raised in a cycle.
    typedef struct packed {
        logic boot;
        logic wake;
        logic write;
    } cause_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sdata: 1'b0, sen_lvl: 1'b1};

    function automatic word_t split_word(input raw_word_t raw);
        return word_t'(raw);
    endfunction

    function automatic logic mask_hit(input logic [NREG-1:0] mask, input addr_t a);
        return mask[a];
    endfunction

    function automatic logic any_cause(input cause_t c);
        return c.boot | c.wake | c.write;
    endfunction

endpackage

// File: rtl/cfgser_sync.sv
`timescale 1ns/1ps
module cfgser_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfgser_shift.sv
`timescale 1ns/1ps
module cfgser_shift
    import cfgser_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  pins_t pins_i,
    output logic  commit_o,
    output word_t word_o
);

    logic      sclk_q;
    logic      sen_q;
    raw_word_t shreg_q;

    logic sclk_rise;
    logic sen_rise;
    logic sen_fall;
    logic active;

    always_comb begin
        sclk_rise = pins_i.sclk & ~sclk_q;
        sen_rise  = pins_i.sen_lvl & ~sen_q;
        sen_fall  = ~pins_i.sen_lvl & sen_q;
        active    = ~pins_i.sen_lvl;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sclk_q  <= 1'b0;
            sen_q   <= 1'b1;
            shreg_q <= '0;
        end else begin
            sclk_q <= pins_i.sclk;
            sen_q  <= pins_i.sen_lvl;
            if (sen_fall) begin
                shreg_q <= '0;
            end else if (active && sclk_rise) begin
                shreg_q <= {shreg_q[WORD_W-2:0], pins_i.sdata};
            end
        end
    end

    assign commit_o = sen_rise;
    assign word_o   = split_word(shreg_q);

endmodule

// File: rtl/cfgser_bank.sv
`timescale 1ns/1ps
module cfgser_bank
    import cfgser_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 16'h0FFF
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   commit_i,
    input  word_t                  word_i,
    output logic [NREG*DATA_W-1:0] regs_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (IMPL_MASK[i]) begin : g_impl
            data_t slot_q;
            logic  wr_en;
            assign wr_en = commit_i && (word_i.addr == addr_t'(i));
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    slot_q <= '0;
                end else if (wr_en) begin
                    slot_q <= word_i.data;
                end
            end
            assign regs_o[i*DATA_W +: DATA_W] = slot_q;
        end else begin : g_empty
            assign regs_o[i*DATA_W +: DATA_W] = '0;
        end
    end

endmodule

// File: rtl/cfgser_retune.sv
`timescale 1ns/1ps
module cfgser_retune
    import cfgser_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 16'h0FFF,
    parameter logic [NREG-1:0] TUNE_MASK = 16'h0038
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  commit_i,
    input  addr_t addr_i,
    input  logic  pwdn_i,
    output logic  retune_o
);

    localparam logic [NREG-1:0] HIT_MASK = IMPL_MASK & TUNE_MASK;

    logic   booted_q;
    logic   pwdn_q;
    logic   retune_q;
    cause_t cause;

    always_comb begin
        cause.boot  = ~booted_q;
        cause.wake  = pwdn_q & ~pwdn_i;
        cause.write = commit_i & mask_hit(HIT_MASK, addr_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            booted_q <= 1'b0;
            pwdn_q   <= pwdn_i;
            retune_q <= 1'b0;
        end else begin
            booted_q <= 1'b1;
            pwdn_q   <= pwdn_i;
            retune_q <= any_cause(cause);
        end
    end

    assign retune_o = retune_q;

endmodule

// File: rtl/cfgser_top.sv
`timescale 1ns/1ps
module cfgser_top
    import cfgser_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 16'h0FFF,
    parameter logic [NREG-1:0] TUNE_MASK = 16'h0038
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   sclk_i,
    input  logic                   sdata_i,
    input  logic                   sen_n_i,
    input  logic                   pwdn_i,
    output logic [NREG*DATA_W-1:0] regs_o,
    output logic                   retune_o
);

    pins_t raw_pins;
    pins_t sync_pins;
    logic  commit_w;
    word_t word_w;

    always_comb begin
        raw_pins.sclk    = sclk_i;
        raw_pins.sdata   = sdata_i;
        raw_pins.sen_lvl = sen_n_i;
    end

    cfgser_sync #(
        .W       ($bits(pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_pins),
        .q_o   (sync_pins)
    );

    cfgser_shift u_shift (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pins_i   (sync_pins),
        .commit_o (commit_w),
        .word_o   (word_w)
    );

    cfgser_bank #(
        .IMPL_MASK (IMPL_MASK)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .commit_i (commit_w),
        .word_i   (word_w),
        .regs_o   (regs_o)
    );

    cfgser_retune #(
        .IMPL_MASK (IMPL_MASK),
        .TUNE_MASK (TUNE_MASK)
    ) u_retune (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .commit_i (commit_w),
        .addr_i   (word_w.addr),
        .pwdn_i   (pwdn_i),
        .retune_o (retune_o)
    );

endmodule

// File: rtl/cfgser_chk.sv
`timescale 1ns/1ps
module cfgser_chk
    import cfgser_pkg::*;
#(
    parameter logic [NREG-1:0] IMPL_MASK = 16'h0FFF,
    parameter logic [NREG-1:0] TUNE_MASK = 16'h0038
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic                   commit_i,
    input word_t                  word_i,
    input logic                   pwdn_i,
    input logic [NREG*DATA_W-1:0] regs_i,
    input logic                   retune_i
);

    localparam logic [NREG-1:0] HIT_MASK = IMPL_MASK & TUNE_MASK;

    // R7: reset leaves the bank and the request at zero
    a_r7_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (regs_i == '0 && !retune_i));

    // R3: without a commit the bank holds its contents
    a_r3_hold_without_commit: assert property (@(posedge clk_i) disable iff (rst_i)
        !commit_i |=> $stable(regs_i));

    // R3: a commit to an implemented slot lands one edge later
    a_r3_commit_lands: assert property (@(posedge clk_i) disable iff (rst_i)
        (commit_i && IMPL_MASK[word_i.addr]) |=>
            (regs_i[$past(word_i.addr)*DATA_W +: DATA_W] == $past(word_i.data)));

    // R9: a frequency-setting write requests a retune
    a_r9_tune_write_pulses: assert property (@(posedge clk_i) disable iff (rst_i)
        (commit_i && HIT_MASK[word_i.addr]) |=> retune_i);

    // R8, R9: other writes, with no boot or wake cause, stay quiet
    a_r9_plain_write_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (commit_i && !HIT_MASK[word_i.addr] && !$fell(pwdn_i) && !$past(rst_i))
            |=> !retune_i);

    // R10: leaving reset requests a retune
    a_r10_boot_pulse: assert property (@(posedge clk_i)
        $fell(rst_i) |=> retune_i);

    // R11: leaving powerdown requests a retune
    a_r11_wake_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pwdn_i) |=> retune_i);

    // R11: a held powerdown alone does not keep the request high
    a_r11_held_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwdn_i && $past(pwdn_i) && !commit_i && !$past(rst_i)) |=> !retune_i);

endmodule

bind cfgser_top cfgser_chk #(
    .IMPL_MASK (IMPL_MASK),
    .TUNE_MASK (TUNE_MASK)
) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .commit_i (commit_w),
    .word_i   (word_w),
    .pwdn_i   (pwdn_i),
    .regs_i   (regs_o),
    .retune_i (retune_o)
);

// File: tb/cfgser_top_tb_top.sv
`timescale 1ns/1ps
module cfgser_top_tb_top;

    localparam int H     = 3;   // system cycles per serial half period
    localparam int NSLOT = 16;
    localparam int DW    = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic sen_n = 1'b1;
    logic pwdn = 1'b0;
    logic [NSLOT*DW-1:0] regs;
    logic retune;

    cfgser_top dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .sclk_i   (sclk),
        .sdata_i  (sdata),
        .sen_n_i  (sen_n),
        .pwdn_i   (pwdn),
        .regs_o   (regs),
        .retune_o (retune)
    );

    always #4 clk = ~clk;

    typedef struct {
        int cyc_due;
        bit wr;
        int addr;
        int data;
        bit rt;
    } ev_t;

    ev_t evq[$];
    bit  bq[$];
    int  mreg[NSLOT];
    bit  exp_rt = 1'b0;
    int  cyc = 0;
    int  tests = 0;
    int  fails = 0;
    bit  mon_on = 1'b0;

    function automatic bit impl(input int a);
        return a < 12;
    endfunction

    function automatic bit tune(input int a);
        return a >= 3 && a <= 5;
    endfunction

    function automatic int rd(input int a);
        return int'(regs[a*DW +: DW]);
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model: advance on every rising edge
    always @(posedge clk) begin
        cyc++;
        exp_rt = 1'b0;
        for (int i = evq.size() - 1; i >= 0; i--) begin
            if (evq[i].cyc_due == cyc) begin
                if (evq[i].wr && impl(evq[i].addr)) begin
                    mreg[evq[i].addr] = evq[i].data;
                    if (tune(evq[i].addr)) exp_rt = 1'b1;
                end
                if (evq[i].rt) exp_rt = 1'b1;
                evq.delete(i);
            end
        end
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            int bad;
            bad = -1;
            for (int a = 0; a < NSLOT; a++) begin
                if (rd(a) != mreg[a] && bad < 0) bad = a;
            end
            tests++;
            if (bad >= 0) begin
                fails++;
                $display("FAIL R3 slot %0d actual=0x%0h expected=0x%0h",
                         bad, rd(bad), mreg[bad]);
            end
            chk("R9 retune per-cycle", int'(retune), int'(exp_rt));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic commit_model();
        logic [21:0] w;
        ev_t e;
        w = '0;
        foreach (bq[i]) w = {w[20:0], bq[i]};
        e.cyc_due = cyc + 3;
        e.wr = 1'b1;
        e.addr = int'(w[3:0]);
        e.data = int'(w[21:4]);
        e.rt = 1'b0;
        evq.push_back(e);
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        sen_n = 1'b0;
        bq.delete();
        wait_n(H);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = bits[i];
            wait_n(H);
            sclk = 1'b1;
            bq.push_back(bits[i]);
            wait_n(H);
            sclk = 1'b0;
        end
        wait_n(H);
        sen_n = 1'b1;
        commit_model();
    endtask

    task automatic push_rt(input int delay);
        ev_t e;
        e.cyc_due = cyc + delay;
        e.wr = 1'b0;
        e.addr = 0;
        e.data = 0;
        e.rt = 1'b1;
        evq.push_back(e);
    endtask

    initial begin
        foreach (mreg[i]) mreg[i] = 0;
        wait_n(5);
        chk("R7 regs in reset", int'(regs != '0), 0);
        chk("R7 retune in reset", int'(retune), 0);
        rst = 1'b0;
        push_rt(1);
        mon_on = 1'b1;
        wait_n(1);
        chk("R10 boot pulse", int'(retune), 1);
        wait_n(1);
        chk("R10 boot pulse ends", int'(retune), 0);
        chk("R7 regs after reset", int'(regs != '0), 0);
        wait_n(4);

        // R1/R9: full word to frequency slot 3
        send({18'h2A5C3, 4'h3}, 22);
        wait_n(2);
        chk("R3 before due", rd(3), 0);
        wait_n(1);
        chk("R1 slot 3 data", rd(3), 'h2A5C3);
        chk("R9 tune write pulse", int'(retune), 1);
        wait_n(1);
        chk("R9 pulse one cycle", int'(retune), 0);
        wait_n(4);

        // R2: bit order
        send({18'h20001, 4'h4}, 22);
        wait_n(3);
        chk("R2 msb first", rd(4), 'h20001);
        wait_n(4);

        // R9: non-frequency slot
        send({18'h155AA, 4'h7}, 22);
        wait_n(3);
        chk("R3 slot 7", rd(7), 'h155AA);
        chk("R9 plain write no pulse", int'(retune), 0);
        wait_n(4);

        // R5: leading junk bits dropped
        send({8'hFF, 18'h12345, 4'h1}, 30);
        wait_n(3);
        chk("R5 long word", rd(1), 'h12345);
        wait_n(4);

        // R6: short word after a frame full of ones
        send({18'h3FFFF, 4'h9}, 22);
        wait_n(6);
        send({6'b101101, 4'h2}, 10);
        wait_n(3);
        chk("R6 short word zero fill", rd(2), 'h2D);
        chk("R6 previous slot kept", rd(9), 'h3FFFF);
        wait_n(4);

        // R6: commit with no clocks writes zero to slot 0
        send({18'h0ABCD, 4'h0}, 22);
        wait_n(6);
        chk("R3 slot 0 set", rd(0), 'h0ABCD);
        send(64'h0, 0);
        wait_n(3);
        chk("R6 empty word", rd(0), 0);
        wait_n(4);

        // R8: unimplemented slots
        send({18'h3FFFF, 4'hD}, 22);
        wait_n(3);
        chk("R8 slot 13 empty", rd(13), 0);
        chk("R8 no pulse", int'(retune), 0);
        wait_n(4);
        send({18'h3FFFF, 4'hF}, 22);
        wait_n(3);
        chk("R8 slot 15 empty", rd(15), 0);
        wait_n(4);

        // R4: clocks while disabled
        sdata = 1'b1;
        for (int k = 0; k < 20; k++) begin
            wait_n(H);
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
        end
        wait_n(6);
        chk("R4 slot 3 kept", rd(3), 'h2A5C3);
        chk("R4 no pulse", int'(retune), 0);

        // R3: overwrite
        send({18'h00FF0, 4'h3}, 22);
        wait_n(3);
        chk("R3 overwrite", rd(3), 'h00FF0);
        chk("R9 second tune pulse", int'(retune), 1);
        wait_n(4);

        // R11: powerdown and wake
        pwdn = 1'b1;
        wait_n(8);
        chk("R11 held quiet", int'(retune), 0);
        pwdn = 1'b0;
        push_rt(1);
        wait_n(1);
        chk("R11 wake pulse", int'(retune), 1);
        wait_n(1);
        chk("R11 wake pulse ends", int'(retune), 0);
        wait_n(6);

        finish_run();
    end

endmodule